// File: doc/BRIEF.md
# SDRAM Mode-Register Programming Front End

This block sits between a simple CPU request port and the command pins of two SDRAM areas. A CPU byte write that lands in one of two reserved 4 KB address windows is turned into a load of that area's mode register. The value loaded is taken from the offset inside the window, not from the write data, and that offset is scaled down according to whether the memory bus is 32 or 16 bits wide. Before the load the block precharges every bank of the target area and pauses. After the load it pauses again. The CPU is held off with a ready handshake until the whole sequence has finished.

Any other access is passed on as a single read or write command with active-low byte masks. The masks are computed from the low address bits, the access size and an endianness strap. Mode loads are refused until a configuration-valid input says the controller's own settings are in place. Refresh, row opening and data timing are handled elsewhere.

The CPU raises `cpu_req` and holds its address, size and direction steady until it sees `cpu_rdy` high for one cycle. The command code is {cs_n, ras_n, cas_n, we_n}, where the chip-select bit is that of the addressed area.

Top module: `sdram_mrs_frontend`

## Requirements
- R1: After reset, and whenever no command is being issued, both chip selects are low and ras_n, cas_n and we_n are high (NOP = 0111), all four byte masks are high, and cpu_rdy is low.
- R2: A byte write (cpu_size 0) with cfg_valid high to 0xFFFFD000+X or 0xFFFFE000+X first issues precharge-all (0010) with address bit 10 high.
- R3: Exactly PRE_CYC NOP cycles separate the precharge-all from the mode-register-set command (0000).
- R4: With bus_is_16 low, the address carried by mode-register-set equals X shifted right by 2 (0x840, 0x880 and 0x8C0 give 0x210, 0x220 and 0x230).
- R5: With bus_is_16 high, the address equals X shifted right by 1 (0x420, 0x440 and 0x460 give 0x210, 0x220 and 0x230).
- R6: The 0xFFFFD window drives only sd_cs_n[0] low during its commands, and the 0xFFFFE window drives only sd_cs_n[1] low. Every non-NOP command drives exactly one chip select low.
- R7: After mode-register-set, exactly POST_CYC NOP cycles pass before cpu_rdy rises, and cpu_rdy does not rise earlier in the sequence.
- R8: A window access is dropped if it is a read, is not byte-sized, or arrives while cfg_valid is low. Only NOPs appear and cpu_rdy goes high in the first cycle after acceptance.
- R9: A normal write issues WRIT (0100) in the first cycle after acceptance, with cpu_rdy high, address = cpu_addr[14:2], and in big-endian mode (endian_big high) sd_dqm_n[3] mapped to byte offset 0 and sd_dqm_n[0] to byte offset 3.
- R10: In little-endian mode, sd_dqm_n[0] maps to byte offset 0 and sd_dqm_n[3] to byte offset 3. Sizes 0, 1 and 2 enable one byte, the halfword at cpu_addr[1], or all four bytes.
- R11: A normal read issues READ (0101). For normal traffic the area is chosen by cpu_addr[26] (0 gives sd_cs_n[0], 1 gives sd_cs_n[1]).
- R12: cpu_rdy is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Controller settings are in place; mode loads are allowed |
| endian_big | input | 1 | Strap: 1 big-endian, 0 little-endian |
| bus_is_16 | input | 1 | Strap: 1 for a 16-bit memory bus, 0 for a 32-bit bus |
| cpu_req | input | 1 | Request, held until cpu_rdy |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_rdy | output | 1 | One-cycle completion pulse |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | SD_ADDR_W | Command address |
| sd_dqm_n | output | 4 | Byte masks, bit 3 uppermost lane |

## Verification
The hardest case to reach from the ports is the timed mode-load sequence. Its precharge, the two NOP gaps and the load must appear in order while the CPU sits stalled with its request held. The scenario tasks hold the request and watch every cycle in a small phase tracker that counts NOPs between the commands, so an off-by-one in either wait is reported. The straps are switched between requests so that both offset scalings are exercised in both windows.

// File: rtl/sdmrs_pkg.sv
// Shared types for the SDRAM mode-register front end.
// Command codes are {cs_n, ras_n, cas_n, we_n}; the low three bits go to the pins.
package sdmrs_pkg;
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_ACTV = 4'b0011,
        CMD_WRIT = 4'b0100,
        CMD_READ = 4'b0101,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ACC_NORMAL = 2'd0,
        ACC_MODE   = 2'd1,
        ACC_DROP   = 2'd2
    } acc_kind_e;

    localparam logic [1:0]  SZ_BYTE = 2'd0;
    localparam logic [1:0]  SZ_HALF = 2'd1;
    localparam logic [19:0] WIN_AREA2 = 20'hFFFFD;
    localparam logic [19:0] WIN_AREA3 = 20'hFFFFE;
endpackage

// File: rtl/sdmrs_win_decode.sv
// Classifies a CPU request: normal traffic, a mode-register load, or a dropped window access.
// Assumes the windows are 4 KB aligned at the package constants; the mode value is the offset scaled by bus width.
module sdmrs_win_decode
    import sdmrs_pkg::*;
#(
    parameter int SD_ADDR_W = 13,
    parameter int AREA_BIT  = 26
) (
    input  logic [31:0]          cpu_addr,
    input  logic                 cpu_we,
    input  logic [1:0]           cpu_size,
    input  logic                 cfg_valid,
    input  logic                 bus_is_16,
    output acc_kind_e            kind,
    output logic                 area,
    output logic [SD_ADDR_W-1:0] mode_val,
    output logic [SD_ADDR_W-1:0] col_addr
);
    logic [19:0] win_hi;
    logic [11:0] win_off;
    logic [11:0] scaled;
    logic        in_a2;
    logic        in_a3;

    // Split the address into window tag and offset.
    always_comb begin
        win_hi  = cpu_addr[31:12];
        win_off = cpu_addr[11:0];
        in_a2   = (win_hi == WIN_AREA2);
        in_a3   = (win_hi == WIN_AREA3);
    end

    // Scale the offset into the mode value: divide by 4 on a 32-bit bus, by 2 on a 16-bit bus.
    always_comb begin
        scaled   = bus_is_16 ? {1'b0, win_off[11:1]} : {2'b00, win_off[11:2]};
        mode_val = SD_ADDR_W'(scaled);
        col_addr = cpu_addr[2 +: SD_ADDR_W];
    end

    // Pick the access kind and the target area.
    always_comb begin
        if (in_a2 || in_a3) begin
            kind = (cpu_we && cpu_size == SZ_BYTE && cfg_valid) ? ACC_MODE : ACC_DROP;
            area = in_a3;
        end else begin
            kind = ACC_NORMAL;
            area = cpu_addr[AREA_BIT];
        end
    end
endmodule

// File: rtl/sdmrs_lane_mask.sv
// Builds the four active-low byte masks from the low address bits, the size and the endianness.
// Assumes halfwords are aligned on cpu_addr[1]; any size other than byte or half enables all lanes.
module sdmrs_lane_mask
    import sdmrs_pkg::*;
(
    input  logic [1:0] byte_off,
    input  logic [1:0] size,
    input  logic       endian_big,
    output logic [3:0] lanes_n
);
    logic [3:0] by_offset;
    logic [3:0] by_lane;

    // Mark which byte offsets inside the word are touched.
    always_comb begin
        case (size)
            SZ_BYTE: by_offset = 4'b0001 << byte_off;
            SZ_HALF: by_offset = 4'b0011 << {byte_off[1], 1'b0};
            default: by_offset = 4'b1111;
        endcase
    end

    // Map offsets to lanes: big-endian reverses the order, little-endian keeps it.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            by_lane[i] = endian_big ? by_offset[3-i] : by_offset[i];
        end
        lanes_n = ~by_lane;
    end
endmodule

// File: rtl/sdmrs_seq.sv
// Command sequencer: issues precharge-all, waits, loads the mode register, waits, then acknowledges.
// Normal accesses and dropped accesses finish in one cycle. All outputs are registered.
// Assumes PRE_CYC and POST_CYC are at least 1 and SD_ADDR_W is at least 11.
module sdmrs_seq
    import sdmrs_pkg::*;
#(
    parameter int SD_ADDR_W = 13,
    parameter int PRE_CYC   = 3,
    parameter int POST_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  acc_kind_e            kind,
    input  logic                 area,
    input  logic [SD_ADDR_W-1:0] mode_val,
    input  logic [SD_ADDR_W-1:0] col_addr,
    input  logic [3:0]           lanes_n,
    output logic [1:0]           cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [SD_ADDR_W-1:0] addr,
    output logic [3:0]           dqm_n,
    output logic                 rdy
);
    localparam int MAX_WAIT = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_PALL, ST_PRE, ST_MRS, ST_POST, ST_DONE
    } seq_state_e;

    seq_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic                 hold_area;
    logic [SD_ADDR_W-1:0] hold_mode;
    sd_cmd_e              cmd_q;

    assign ras_n = cmd_q[2];
    assign cas_n = cmd_q[1];
    assign we_n  = cmd_q[0];
    assign rdy   = (state == ST_DONE);

    // Advance the sequence and register the command, chip selects, address and masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            hold_area <= 1'b0;
            hold_mode <= '0;
            cmd_q     <= CMD_NOP;
            cs_n      <= 2'b00;
            addr      <= '0;
            dqm_n     <= 4'hF;
        end else begin
            cmd_q <= CMD_NOP;
            cs_n  <= 2'b00;
            addr  <= '0;
            dqm_n <= 4'hF;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        case (kind)
                            ACC_MODE: begin
                                state     <= ST_PALL;
                                hold_area <= area;
                                hold_mode <= mode_val;
                                cmd_q     <= CMD_PALL;
                                cs_n      <= area ? 2'b01 : 2'b10;
                                addr      <= SD_ADDR_W'(1) << 10;
                            end
                            ACC_NORMAL: begin
                                state <= ST_DONE;
                                cmd_q <= we ? CMD_WRIT : CMD_READ;
                                cs_n  <= area ? 2'b01 : 2'b10;
                                addr  <= col_addr;
                                dqm_n <= lanes_n;
                            end
                            default: state <= ST_DONE;
                        endcase
                    end
                end
                ST_PALL: begin
                    state <= ST_PRE;
                    cnt   <= CNT_W'(PRE_CYC - 1);
                end
                ST_PRE: begin
                    if (cnt == '0) begin
                        state <= ST_MRS;
                        cmd_q <= CMD_MRS;
                        cs_n  <= hold_area ? 2'b01 : 2'b10;
                        addr  <= hold_mode;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_MRS: begin
                    state <= ST_POST;
                    cnt   <= CNT_W'(POST_CYC - 1);
                end
                ST_POST: begin
                    if (cnt == '0) state <= ST_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the mode load is only reached from the pre-load wait.
    p_mrs_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MRS) |-> ($past(state) == ST_PRE));

    // R2: precharge-all drives bit 10 high with the precharge pin pattern.
    p_pall_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PALL) |-> (addr[10] && !ras_n && cas_n && !we_n));

    // R12: the acknowledge never lasts two cycles.
    p_rdy_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R7: the acknowledge after a mode load follows the post-load wait.
    p_post_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MRS) |=> (state == ST_POST && !rdy));
endmodule

// File: rtl/sdram_mrs_frontend.sv
// Top of the SDRAM mode-register programming front end.
// Decodes CPU requests, builds byte masks and sequences SDRAM commands for two areas.
// Assumes the CPU holds its request steady until cpu_rdy is seen.
module sdram_mrs_frontend
    import sdmrs_pkg::*;
#(
    parameter int SD_ADDR_W = 13,
    parameter int AREA_BIT  = 26,
    parameter int PRE_CYC   = 3,
    parameter int POST_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic                 endian_big,
    input  logic                 bus_is_16,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [1:0]           cpu_size,
    input  logic [31:0]          cpu_addr,
    output logic                 cpu_rdy,
    output logic [1:0]           sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [SD_ADDR_W-1:0] sd_addr,
    output logic [3:0]           sd_dqm_n
);
    acc_kind_e            kind;
    logic                 area;
    logic [SD_ADDR_W-1:0] mode_val;
    logic [SD_ADDR_W-1:0] col_addr;
    logic [3:0]           lanes_n;

    sdmrs_win_decode #(.SD_ADDR_W(SD_ADDR_W), .AREA_BIT(AREA_BIT)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .cpu_size (cpu_size),
        .cfg_valid(cfg_valid),
        .bus_is_16(bus_is_16),
        .kind     (kind),
        .area     (area),
        .mode_val (mode_val),
        .col_addr (col_addr)
    );

    sdmrs_lane_mask u_mask (
        .byte_off  (cpu_addr[1:0]),
        .size      (cpu_size),
        .endian_big(endian_big),
        .lanes_n   (lanes_n)
    );

    sdmrs_seq #(.SD_ADDR_W(SD_ADDR_W), .PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cpu_req),
        .we      (cpu_we),
        .kind    (kind),
        .area    (area),
        .mode_val(mode_val),
        .col_addr(col_addr),
        .lanes_n (lanes_n),
        .cs_n    (sd_cs_n),
        .ras_n   (sd_ras_n),
        .cas_n   (sd_cas_n),
        .we_n    (sd_we_n),
        .addr    (sd_addr),
        .dqm_n   (sd_dqm_n),
        .rdy     (cpu_rdy)
    );

    // R6: any real command selects exactly one area.
    p_single_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) |-> ($countones(sd_cs_n) == 1));

    // R9: masks stay high unless a read or write is on the pins.
    p_mask_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !({sd_ras_n, sd_cas_n} == 2'b10) |-> (sd_dqm_n == 4'hF));

    // R10: a read or write enables one, two or four lanes.
    p_lane_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n} == 2'b10) |->
        ($countones(~sd_dqm_n) == 1 || $countones(~sd_dqm_n) == 2 || $countones(~sd_dqm_n) == 4));
endmodule

// File: tb/sdram_mrs_frontend_tb.sv
// Directed bench: one task per scenario, each checking its own results at the falling edge.
module sdram_mrs_frontend_tb_top;
    localparam int AW   = 13;
    localparam int PRE  = 3;
    localparam int POST = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic          endian_big = 1'b1;
    logic          bus_is_16 = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [1:0]    cpu_size = 2'd0;
    logic [31:0]   cpu_addr = 32'h0;
    logic          cpu_rdy;
    logic [1:0]    sd_cs_n;
    logic          sd_ras_n;
    logic          sd_cas_n;
    logic          sd_we_n;
    logic [AW-1:0] sd_addr;
    logic [3:0]    sd_dqm_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    sdram_mrs_frontend #(.SD_ADDR_W(AW), .AREA_BIT(26), .PRE_CYC(PRE), .POST_CYC(POST)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .endian_big(endian_big),
        .bus_is_16(bus_is_16), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_rdy(cpu_rdy), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dqm_n(sd_dqm_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] cmd3();
        return {1'b0, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(sd_cs_n == 2'b00, "R1 cs", 32'(sd_cs_n), 32'h0);
        chk(cmd3() == 4'h7, "R1 nop", 32'(cmd3()), 32'h7);
        chk(sd_dqm_n == 4'hF, "R1 dqm", 32'(sd_dqm_n), 32'hF);
        chk(cpu_rdy == 1'b0, "R1 rdy", 32'(cpu_rdy), 32'h0);
    endtask

    // Mode load: precharge, PRE NOPs, load, POST NOPs, acknowledge.
    task automatic t_mode(input logic [31:0] a, input logic b16, input logic [AW-1:0] exp_mode,
                          input logic [1:0] exp_cs, input string mtag);
        int phase = 0;
        int nops  = 0;
        @(negedge clk);
        bus_is_16 = b16; cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'd0; cpu_addr = a;
        for (int i = 0; i < 64 && phase < 3; i++) begin
            @(negedge clk);
            case (phase)
                0: begin
                    chk(cmd3() == 4'h2 && sd_addr[10], "R2 pall", 32'(cmd3()), 32'h2);
                    chk(sd_cs_n == exp_cs, "R6 pall cs", 32'(sd_cs_n), 32'(exp_cs));
                    phase = 1;
                end
                1: begin
                    chk(!cpu_rdy, "R7 early rdy", 32'(cpu_rdy), 32'h0);
                    if (cmd3() == 4'h7) nops++;
                    else begin
                        chk(nops == PRE, "R3 pre gap", 32'(nops), 32'(PRE));
                        chk(cmd3() == 4'h0, "R3 mrs code", 32'(cmd3()), 32'h0);
                        chk(sd_cs_n == exp_cs, "R6 mrs cs", 32'(sd_cs_n), 32'(exp_cs));
                        chk(sd_addr == exp_mode, mtag, 32'(sd_addr), 32'(exp_mode));
                        nops = 0; phase = 2;
                    end
                end
                default: begin
                    if (cpu_rdy) begin
                        chk(nops == POST, "R7 post gap", 32'(nops), 32'(POST));
                        cpu_req = 1'b0; phase = 3;
                    end else if (cmd3() == 4'h7) nops++;
                    else chk(1'b0, "R7 stray cmd", 32'(cmd3()), 32'h7);
                end
            endcase
        end
        chk(phase == 3, "R7 sequence done", 32'(phase), 32'h3);
        @(negedge clk);
        chk(!cpu_rdy, "R12 rdy one cycle", 32'(cpu_rdy), 32'h0);
    endtask

    // Dropped window access: NOP only, acknowledge next cycle.
    task automatic t_drop(input logic [31:0] a, input logic w, input logic [1:0] sz, input logic cv);
        @(negedge clk);
        cfg_valid = cv; cpu_req = 1'b1; cpu_we = w; cpu_size = sz; cpu_addr = a;
        @(negedge clk);
        chk(cpu_rdy, "R8 drop rdy", 32'(cpu_rdy), 32'h1);
        chk(cmd3() == 4'h7 && sd_cs_n == 2'b00, "R8 drop nop", 32'(cmd3()), 32'h7);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_rdy && cmd3() == 4'h7, "R8 still idle", 32'(cmd3()), 32'h7);
        cfg_valid = 1'b1;
    endtask

    // Normal read or write with byte masks.
    task automatic t_norm(input logic [31:0] a, input logic w, input logic [1:0] sz, input logic big,
                          input logic [3:0] exp_dqm, input logic [1:0] exp_cs, input string tag);
        logic [AW-1:0] exp_col;
        exp_col = a[2 +: AW];
        @(negedge clk);
        endian_big = big; cpu_req = 1'b1; cpu_we = w; cpu_size = sz; cpu_addr = a;
        @(negedge clk);
        chk(cmd3() == (w ? 4'h4 : 4'h5), w ? "R9 writ code" : "R11 read code", 32'(cmd3()), w ? 32'h4 : 32'h5);
        chk(sd_cs_n == exp_cs, "R11 area cs", 32'(sd_cs_n), 32'(exp_cs));
        chk(sd_addr == exp_col, "R9 column", 32'(sd_addr), 32'(exp_col));
        chk(sd_dqm_n == exp_dqm, tag, 32'(sd_dqm_n), 32'(exp_dqm));
        chk(cpu_rdy, "R12 rdy", 32'(cpu_rdy), 32'h1);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_rdy && sd_dqm_n == 4'hF, "R12 rdy drop", 32'(cpu_rdy), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_drop(32'hFFFF_D840, 1'b1, 2'd0, 1'b0);
        t_mode(32'hFFFF_D840, 1'b0, 13'h210, 2'b10, "R4 cl1 32b");
        t_mode(32'hFFFF_E880, 1'b0, 13'h220, 2'b01, "R4 cl2 32b");
        t_mode(32'hFFFF_E8C0, 1'b0, 13'h230, 2'b01, "R4 cl3 32b");
        t_mode(32'hFFFF_D420, 1'b1, 13'h210, 2'b10, "R5 cl1 16b");
        t_mode(32'hFFFF_E460, 1'b1, 13'h230, 2'b01, "R5 cl3 16b");
        t_drop(32'hFFFF_D840, 1'b1, 2'd1, 1'b1);
        t_drop(32'hFFFF_E840, 1'b0, 2'd0, 1'b1);
        t_norm(32'h0400_0104, 1'b1, 2'd0, 1'b1, 4'h7, 2'b01, "R9 be byte0");
        t_norm(32'h0000_0225, 1'b1, 2'd0, 1'b1, 4'hB, 2'b10, "R9 be byte1");
        t_norm(32'h0000_0302, 1'b1, 2'd1, 1'b1, 4'hC, 2'b10, "R9 be half2");
        t_norm(32'h0000_0100, 1'b0, 2'd0, 1'b0, 4'hE, 2'b10, "R10 le byte0");
        t_norm(32'h0400_0103, 1'b0, 2'd0, 1'b0, 4'h7, 2'b01, "R10 le byte3");
        t_norm(32'h0000_0102, 1'b0, 2'd1, 1'b0, 4'h3, 2'b10, "R10 le half2");
        t_norm(32'h0400_0ABC, 1'b0, 2'd2, 1'b0, 4'h0, 2'b01, "R10 le word");
        t_mode(32'hFFFF_D880, 1'b0, 13'h220, 2'b10, "R4 after traffic");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule